// File: doc/BRIEF.md
# Control Endpoint Mode Register With Write Lock

This block holds the 8-bit mode and status byte of a low-speed USB control endpoint. Two agents share it. The serial interface engine reports transaction events on one side and reads back the 4-bit handshake mode. A CPU reads and writes the byte through strobes on the other side.

The top three status flags and the ACK flag record what happened on the bus. The low nibble selects how the engine answers each token. When the engine changes anything in bits 6:0, the byte locks. All CPU writes are then dropped until the CPU reads the byte. This way firmware cannot overwrite an event it has not yet seen.

While a SETUP data phase is in progress, the SETUP flag is pinned high, and the same flag blocks CPU writes into the endpoint FIFO. The block also decodes the handshake the engine should return for the current token. After an ACKed OUT in the ACK-OUT/NAK-IN mode, it moves the mode field back to NAK-all on its own.

Top module: `ctl_ep_mode_reg`

## Requirements
- R1: Register layout is bit 7 SETUP seen, bit 6 IN done, bit 5 OUT done, bit 4 ACKed, bits 3:0 mode. After reset every bit reads 0, the FIFO block output is 0 and the mode output is 0.
- R2: An engine event that changes bits 6:0 locks the register. The events are IN done, OUT done, ACK, and the automatic mode change. While locked, every CPU write is dropped until a CPU read.
- R3: A CPU write accepted while unlocked clears bits 7:4 whatever the data. It loads only its 4-bit data into bits 3:0.
- R4: A SETUP-start event sets bit 7 and opens a window that lasts until the SETUP-end event. Inside the window, CPU writes cannot clear bit 7. SETUP-start and SETUP-end do not lock the register.
- R5: The FIFO write-block output equals 1 exactly while bit 7 is 1.
- R6: An IN-done event sets bit 6 and an OUT-done event sets bit 5 at the next clock edge.
- R7: An ACK event sets bit 4 at the next clock edge.
- R8: The handshake output is decoded as follows. Token codes are 0 none, 1 SETUP, 2 IN, 3 OUT. Handshake codes are 0 none, 1 ACK, 2 NAK, 3 STALL.
  - With no token, the output is none.
  - Mode 0001: SETUP gets ACK; IN and OUT get NAK.
  - Mode 1011: SETUP and OUT get ACK; IN gets NAK.
  - Every other mode: STALL.
- R9: An ACK event presented with token OUT while the mode is 1011 sets the mode to 0001. An ACK with any other token leaves the mode unchanged.
- R10: A CPU write in the same cycle as any engine event is dropped. If that event changes bits 6:0, the register also locks.
- R11: A CPU read returns the value held before any engine update in the same cycle, and the read clears the lock. An update that locks in the same cycle as the read keeps the lock set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_mode_wdata_i | input | 4 | CPU write data for the mode field |
| cpu_rdata_o | output | 8 | Register value during a read, else 0 |
| fifo_wr_block_o | output | 1 | Suppresses CPU writes into the endpoint FIFO |
| sie_setup_start_i | input | 1 | SETUP data phase begins |
| sie_setup_end_i | input | 1 | ACK for the SETUP begins |
| sie_in_done_i | input | 1 | Last packet of an IN transaction done |
| sie_out_done_i | input | 1 | Last packet of an OUT transaction done |
| sie_ack_i | input | 1 | Transaction completed with ACK |
| sie_tok_i | input | 2 | Current token type |
| sie_mode_o | output | 4 | Current mode field |
| sie_hs_o | output | 2 | Handshake decision for the token |

## Verification
The bench uses the fixed 4-bit mode and 2-bit token widths. That keeps the state small enough to sweep it completely.

All 16 modes are paired with all 4 token codes, so the whole handshake table is checked against an arithmetic model. Every write value is applied after an event-and-unlock sequence, which checks the clear-on-write and the status flags on each of them.

Directed sequences cover the remaining orderings:
- a write colliding with an event in the same cycle;
- a read colliding with an event in the same cycle;
- a write made inside the SETUP window;
- the automatic mode fall-back.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam int MODE_W = 4;
  localparam int REG_W  = 8;
  localparam int TOK_W  = 2;
  localparam int HS_W   = 2;

  typedef enum logic [TOK_W-1:0] {
    TOK_NONE  = 2'd0,
    TOK_SETUP = 2'd1,
    TOK_IN    = 2'd2,
    TOK_OUT   = 2'd3
  } tok_e;

  typedef enum logic [HS_W-1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam logic [MODE_W-1:0] MODE_NAK_ALL    = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_ACKOUT_NAKIN = 4'b1011;

  typedef struct packed {
    logic              setup_rx;
    logic              in_rx;
    logic              out_rx;
    logic              acked;
    logic [MODE_W-1:0] mode;
  } ep_reg_t;
endpackage

// File: rtl/ctl_ep_lock.sv
module ctl_ep_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_rd_i,
  input  logic cpu_wr_i,
  input  logic sie_lock_evt_i,
  input  logic sie_any_evt_i,
  output logic locked_o,
  output logic wr_ok_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lock_q <= 1'b0;
    else if (sie_lock_evt_i) lock_q <= 1'b1;
    else if (cpu_rd_i)       lock_q <= 1'b0;
  end

  assign locked_o = lock_q;
  assign wr_ok_o  = cpu_wr_i & ~lock_q & ~sie_any_evt_i;

  // R2
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !cpu_rd_i |=> lock_q);

  // R11
  rd_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && !sie_lock_evt_i |=> !lock_q);

  // R10
  collide_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && sie_lock_evt_i |=> lock_q);
endmodule

// File: rtl/ctl_ep_status.sv
module ctl_ep_status
  import ctl_ep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_start_i,
  input  logic              setup_end_i,
  input  logic              in_done_i,
  input  logic              out_done_i,
  input  logic              ack_i,
  input  logic              auto_mode_i,
  input  logic              wr_ok_i,
  input  logic [MODE_W-1:0] wmode_i,
  output logic [REG_W-1:0]  reg_o,
  output logic              window_o
);
  ep_reg_t reg_q, reg_d;
  logic    win_q, win_d;

  always_comb begin
    win_d = win_q;
    if (setup_start_i)    win_d = 1'b1;
    else if (setup_end_i) win_d = 1'b0;
  end

  always_comb begin
    reg_d = reg_q;
    if (setup_start_i)          reg_d.setup_rx = 1'b1;
    else if (wr_ok_i && !win_q) reg_d.setup_rx = 1'b0;

    if (in_done_i)    reg_d.in_rx = 1'b1;
    else if (wr_ok_i) reg_d.in_rx = 1'b0;

    if (out_done_i)   reg_d.out_rx = 1'b1;
    else if (wr_ok_i) reg_d.out_rx = 1'b0;

    if (ack_i)        reg_d.acked = 1'b1;
    else if (wr_ok_i) reg_d.acked = 1'b0;

    if (auto_mode_i)  reg_d.mode = MODE_NAK_ALL;
    else if (wr_ok_i) reg_d.mode = wmode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      win_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      win_q <= win_d;
    end
  end

  assign reg_o    = reg_q;
  assign window_o = win_q;

  // R4
  window_bit7_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |-> reg_q.setup_rx);

  // R6
  in_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_done_i |=> reg_q.in_rx);

  // R6
  out_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_i |=> reg_q.out_rx);

  // R7
  ack_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> reg_q.acked);

  // R3
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_i && !setup_start_i && !in_done_i && !out_done_i && !ack_i && !auto_mode_i
    |=> reg_q[6:4] == 3'b000 && reg_q.mode == $past(wmode_i));

  // R9
  auto_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_mode_i |=> reg_q.mode == MODE_NAK_ALL);
endmodule

// File: rtl/ctl_ep_hs_dec.sv
module ctl_ep_hs_dec
  import ctl_ep_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TOK_W-1:0]  tok_i,
  output logic [HS_W-1:0]   hs_o
);
  always_comb begin
    hs_o = HS_STALL;
    if (tok_i == TOK_NONE) begin
      hs_o = HS_NONE;
    end else if (mode_i == MODE_NAK_ALL) begin
      hs_o = (tok_i == TOK_SETUP) ? HS_ACK : HS_NAK;
    end else if (mode_i == MODE_ACKOUT_NAKIN) begin
      hs_o = (tok_i == TOK_IN) ? HS_NAK : HS_ACK;
    end
  end
endmodule

// File: rtl/ctl_ep_mode_reg.sv
module ctl_ep_mode_reg
  import ctl_ep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [MODE_W-1:0] cpu_mode_wdata_i,
  output logic [REG_W-1:0]  cpu_rdata_o,
  output logic              fifo_wr_block_o,
  input  logic              sie_setup_start_i,
  input  logic              sie_setup_end_i,
  input  logic              sie_in_done_i,
  input  logic              sie_out_done_i,
  input  logic              sie_ack_i,
  input  logic [TOK_W-1:0]  sie_tok_i,
  output logic [MODE_W-1:0] sie_mode_o,
  output logic [HS_W-1:0]   sie_hs_o
);
  logic [REG_W-1:0] reg_val;
  logic             locked, wr_ok, window;
  logic             auto_mode, lock_evt, any_evt;

  assign auto_mode = sie_ack_i && (sie_tok_i == TOK_OUT)
                  && (reg_val[MODE_W-1:0] == MODE_ACKOUT_NAKIN);
  assign lock_evt  = sie_in_done_i | sie_out_done_i | sie_ack_i | auto_mode;
  assign any_evt   = lock_evt | sie_setup_start_i | sie_setup_end_i;

  ctl_ep_lock u_lock (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpu_rd_i       (cpu_rd_i),
    .cpu_wr_i       (cpu_wr_i),
    .sie_lock_evt_i (lock_evt),
    .sie_any_evt_i  (any_evt),
    .locked_o       (locked),
    .wr_ok_o        (wr_ok)
  );

  ctl_ep_status u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .setup_start_i (sie_setup_start_i),
    .setup_end_i   (sie_setup_end_i),
    .in_done_i     (sie_in_done_i),
    .out_done_i    (sie_out_done_i),
    .ack_i         (sie_ack_i),
    .auto_mode_i   (auto_mode),
    .wr_ok_i       (wr_ok),
    .wmode_i       (cpu_mode_wdata_i),
    .reg_o         (reg_val),
    .window_o      (window)
  );

  ctl_ep_hs_dec u_hs (
    .mode_i (reg_val[MODE_W-1:0]),
    .tok_i  (sie_tok_i),
    .hs_o   (sie_hs_o)
  );

  assign cpu_rdata_o     = cpu_rd_i ? reg_val : '0;
  assign fifo_wr_block_o = reg_val[REG_W-1];
  assign sie_mode_o      = reg_val[MODE_W-1:0];

  // R2
  locked_wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && cpu_wr_i && !any_evt |=> $stable(reg_val));

  // R5
  fifo_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_setup_start_i |=> fifo_wr_block_o);

  // R4
  window_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window && !sie_setup_end_i |=> fifo_wr_block_o);

  // R8
  stall_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_tok_i != TOK_NONE && sie_mode_o != MODE_NAK_ALL && sie_mode_o != MODE_ACKOUT_NAKIN
    |-> sie_hs_o == HS_STALL);

  // R10
  collide_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && any_evt && !auto_mode |=> sie_mode_o == $past(sie_mode_o));
endmodule

// File: tb/ctl_ep_mode_reg_bench.sv
`timescale 1ns/1ps
module ctl_ep_mode_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
  logic [3:0] cpu_mode_wdata_i = '0;
  logic [7:0] cpu_rdata_o;
  logic       fifo_wr_block_o;
  logic       sie_setup_start_i = 1'b0, sie_setup_end_i = 1'b0;
  logic       sie_in_done_i = 1'b0, sie_out_done_i = 1'b0, sie_ack_i = 1'b0;
  logic [1:0] sie_tok_i = '0;
  logic [3:0] sie_mode_o;
  logic [1:0] sie_hs_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ctl_ep_mode_reg u_ctl_ep_mode_reg (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [7:0] exp);
    cpu_rd_i = 1'b1;
    #1;
    chk(tag, cpu_rdata_o, exp);
    tick();
    cpu_rd_i = 1'b0;
  endtask

  task automatic wr(logic [3:0] m);
    cpu_wr_i = 1'b1;
    cpu_mode_wdata_i = m;
    tick();
    cpu_wr_i = 1'b0;
  endtask

  task automatic evt(logic ss, logic se, logic ind, logic outd, logic ack, logic [1:0] tok);
    sie_setup_start_i = ss; sie_setup_end_i = se;
    sie_in_done_i = ind; sie_out_done_i = outd; sie_ack_i = ack; sie_tok_i = tok;
    tick();
    sie_setup_start_i = 0; sie_setup_end_i = 0;
    sie_in_done_i = 0; sie_out_done_i = 0; sie_ack_i = 0; sie_tok_i = 0;
  endtask

  function automatic logic [1:0] exp_hs(logic [3:0] m, logic [1:0] t);
    if (t == 2'd0) return 2'd0;
    if (m == 4'b0001) return (t == 2'd1) ? 2'd1 : 2'd2;
    if (m == 4'b1011) return (t == 2'd2) ? 2'd2 : 2'd1;
    return 2'd3;
  endfunction

  initial begin
    logic [3:0] m_exp;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk("R1 fifo", {7'd0, fifo_wr_block_o}, 8'h00);
    chk("R1 mode", {4'd0, sie_mode_o}, 8'h00);
    rd_chk("R1 reg", 8'h00);

    // R3 R6 R7 sweep over every write value
    m_exp = 4'h0;
    for (int v = 0; v < 256; v++) begin
      evt(0, 0, 1, 0, 1, 2'd2);
      rd_chk("R6 R7 in+ack", {4'b0101, m_exp});
      wr(v[3:0]);
      m_exp = v[3:0];
      rd_chk("R3 write", {4'h0, m_exp});
    end
    evt(0, 0, 0, 1, 0, 2'd0);
    rd_chk("R6 out", {4'b0010, m_exp});

    // R2 lock drops writes until read
    wr(4'h0); rd_chk("R3 clr", 8'h00);
    evt(0, 0, 1, 0, 0, 2'd0);
    wr(4'hA);
    chk("R2 mode held", {4'd0, sie_mode_o}, 8'h00);
    rd_chk("R2 locked", 8'h40);
    wr(4'hA);
    rd_chk("R2 unlocked", 8'h0A);

    // R11 read with simultaneous update: old value, lock stays
    cpu_rd_i = 1'b1; sie_in_done_i = 1'b1;
    #1;
    chk("R11 pre-update", cpu_rdata_o, 8'h0A);
    tick();
    cpu_rd_i = 1'b0; sie_in_done_i = 1'b0;
    wr(4'h5);
    rd_chk("R11 lock kept", 8'h4A);
    wr(4'h5);
    rd_chk("R11 unlocked", 8'h05);

    // R10 write colliding with event
    cpu_wr_i = 1'b1; cpu_mode_wdata_i = 4'h3; sie_out_done_i = 1'b1;
    tick();
    cpu_wr_i = 1'b0; sie_out_done_i = 1'b0;
    wr(4'h3);
    rd_chk("R10 collide", 8'h25);
    wr(4'h3);
    rd_chk("R10 after", 8'h03);

    // R4 R5 SETUP window
    evt(1, 0, 0, 0, 0, 2'd1);
    chk("R5 block on", {7'd0, fifo_wr_block_o}, 8'h01);
    wr(4'h7);
    rd_chk("R4 bit7 held no lock", 8'h87);
    evt(0, 0, 1, 0, 0, 2'd0);
    rd_chk("R4 in during window", 8'hC7);
    evt(0, 1, 0, 0, 0, 2'd0);
    rd_chk("R4 after end", 8'hC7);
    wr(4'h2);
    rd_chk("R4 cleared", 8'h02);
    chk("R5 block off", {7'd0, fifo_wr_block_o}, 8'h00);

    // R9 automatic mode change
    wr(4'hB);
    evt(0, 0, 0, 0, 1, 2'd2);
    rd_chk("R9 ack IN keeps", 8'h1B);
    evt(0, 0, 0, 0, 1, 2'd3);
    chk("R9 mode out", {4'd0, sie_mode_o}, 8'h01);
    rd_chk("R9 ack OUT", 8'h11);

    // R8 handshake table sweep
    for (int m = 0; m < 16; m++) begin
      wr(m[3:0]);
      rd_chk("R8 mode set", {4'h0, m[3:0]});
      for (int t = 0; t < 4; t++) begin
        sie_tok_i = t[1:0];
        #1;
        chk("R8 hs", {6'd0, sie_hs_o}, {6'd0, exp_hs(m[3:0], t[1:0])});
      end
      sie_tok_i = 2'd0;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule